// File: doc/BRIEF.md
# DDS Profile Frame Serializer

This block turns one synthesizer channel profile into a single write burst on a 4-bit serial data link. The burst has only a data phase: no instruction byte and no address phase. The profile is made of a channel number, a two-bit link-mode code, a 32-bit frequency tuning word, a phase offset and an amplitude code. The block packs these into four back-to-back register writes that together fill a fixed 16-byte frame. That frame is then shifted out one nibble per serial clock.

The frame holds four groups of four bytes. The first group selects the channel. The second group carries the amplitude control. The third carries the phase offset and ends with the tuning-word register address. The fourth is the tuning word itself. When the burst is over and chip select has returned high, a single-cycle strobe tells a downstream timer that it may fire the update pulse which makes the new profile take effect.

A client offers a profile by raising `start` while `ready` is high. The profile inputs are captured on that clock edge. A serial clock cycle spans two system clocks: one with the clock low, then one with the clock high.

Top module: `dds_profile_serializer`

## Requirements
- R1: Out of reset, `cs_n` is 1, `sclk` is 0, `ready` is 1 and `done` is 0.
- R2: One accepted profile produces exactly 16 bytes as 32 nibbles, with the high nibble of each byte first. `cs_n` stays low for exactly 66 system cycles: 1 lead cycle, 64 shift cycles and 1 tail cycle.
- R3: Bytes 0 to 3 are 0x00, S, 0x00, S. In the select value S, bits 2:1 equal `mode`, bit (4 + `chan`) is 1, and every other bit is 0.
- R4: Bytes 4 to 7 are 0x06 followed by a 24-bit amplitude word, most significant byte first. The word's bits 9:0 equal `amp[9:0]`. Its bit 12 is 1 exactly when `amp` < 1024. All other bits are 0, so `amp` = 1024 gives 0x000000.
- R5: Bytes 8 to 11 are 0x05, then the 16-bit phase field most significant byte first, then 0x04. The phase field's bits 13:0 equal `phase[13:0]` and its bits 15:14 are 0, whatever `phase[15:14]` holds.
- R6: Bytes 12 to 15 are `ftw`, most significant byte first.
- R7: `sclk` is high only while `cs_n` is low. `qd` changes only when `sclk` falls or while `sclk` is low. It holds steady throughout every `sclk`-high cycle.
- R8: In the first cycle with `cs_n` low, `sclk` is 0. In the last cycle with `cs_n` low, `sclk` is 0, and the cycle before it has `sclk` high for the final nibble.
- R9: `done` is high for exactly one cycle: the first cycle in which `cs_n` is back high after a burst.
- R10: `ready` is low from the cycle after `start` is accepted up to the `done` cycle. A `start` raised while `ready` is low changes neither the frame in progress nor the bursts that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Request to send the profile on the inputs |
| chan | input | 2 | Channel to address (0 to 3) |
| mode | input | 2 | Link-mode code placed in the select value |
| ftw | input | 32 | Frequency tuning word |
| phase | input | 16 | Phase offset; only bits 13:0 are used |
| amp | input | 11 | Amplitude code, 1024 is full scale |
| ready | output | 1 | Idle; a start is accepted |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| qd | output | 4 | Serial data nibble |
| done | output | 1 | One-cycle strobe at the end of a burst |

## Verification
Random profiles spread values across every byte lane. Because of that, a swapped byte, a reversed nibble order or a misplaced field shows up as a mismatch in a specific byte group. Directed profiles then press on the edges of the amplitude encoding:
- `amp` 1024, where the multiplier bit must clear and the amplitude bits wrap to zero;
- 1023 and 0, where the multiplier bit must be set;
- a phase value with its top two bits set, which tests the masking;
- each of the four channel numbers, which move the select bit.

One burst receives a second start in the middle with a different profile. That burst separates a block that ignores the request while busy from one that reloads its frame or queues a second burst.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_LEAD  = 2'd1,
    SH_SHIFT = 2'd2,
    SH_TAIL  = 2'd3
  } sh_state_t;

  // Channel-select value: link mode in bits 2:1, one enable bit per channel from bit 4.
  function automatic logic [7:0] sel_value(input logic [1:0] ch, input logic [1:0] md);
    logic [7:0] v;
    v = 8'h00;
    v[2:1] = md;
    v[4 + int'(ch)] = 1'b1;
    return v;
  endfunction

  // Amplitude word: code in 9:0, multiplier enable in bit 12 while below full scale.
  function automatic logic [23:0] amp_value(input logic [10:0] a);
    logic [23:0] w;
    w = 24'h000000;
    w[9:0] = a[9:0];
    w[12]  = (a < 11'd1024);
    return w;
  endfunction

  // Phase field: 14 significant bits, upper two forced to zero.
  function automatic logic [15:0] phase_value(input logic [15:0] p);
    return {2'b00, p[13:0]};
  endfunction

endpackage

// File: rtl/dps_frame_packer.sv
module dps_frame_packer
  import dps_pkg::*;
#(
  parameter int          FRAME_BYTES = 16,
  parameter logic [7:0]  ADDR_SEL    = 8'h00,
  parameter logic [7:0]  ADDR_AMP    = 8'h06,
  parameter logic [7:0]  ADDR_PHASE  = 8'h05,
  parameter logic [7:0]  ADDR_FTW    = 8'h04,
  localparam int         FRAME_W     = FRAME_BYTES * 8
) (
  input  logic [1:0]         chan,
  input  logic [1:0]         mode,
  input  logic [31:0]        ftw,
  input  logic [15:0]        phase,
  input  logic [10:0]        amp,
  output logic [FRAME_W-1:0] frame
);

  logic [7:0]  fb [FRAME_BYTES];
  logic [7:0]  sel_b;
  logic [23:0] amp_w;
  logic [15:0] ph_w;

  assign sel_b = sel_value(chan, mode);
  assign amp_w = amp_value(amp);
  assign ph_w  = phase_value(phase);

  always_comb begin
    for (int i = 0; i < FRAME_BYTES; i++) fb[i] = 8'h00;
    fb[0]  = ADDR_SEL;
    fb[1]  = sel_b;
    fb[2]  = ADDR_SEL;
    fb[3]  = sel_b;
    fb[4]  = ADDR_AMP;
    fb[5]  = amp_w[23:16];
    fb[6]  = amp_w[15:8];
    fb[7]  = amp_w[7:0];
    fb[8]  = ADDR_PHASE;
    fb[9]  = ph_w[15:8];
    fb[10] = ph_w[7:0];
    fb[11] = ADDR_FTW;
    fb[12] = ftw[31:24];
    fb[13] = ftw[23:16];
    fb[14] = ftw[15:8];
    fb[15] = ftw[7:0];
  end

  // Byte 0 leaves the link first, so it occupies the top of the frame vector.
  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_flat
    assign frame[FRAME_W-1-8*g -: 8] = fb[g];
  end

endmodule

// File: rtl/dps_nibble_shifter.sv
module dps_nibble_shifter
  import dps_pkg::*;
#(
  parameter int  FRAME_W = 128,
  parameter int  NIB_W   = 4,
  localparam int NIBBLES = FRAME_W / NIB_W,
  localparam int PHASES  = NIBBLES * 2,
  localparam int CNT_W   = $clog2(PHASES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  output logic               ready,
  output logic               sclk,
  output logic               cs_n,
  output logic [NIB_W-1:0]   qd,
  output logic               done
);

  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(PHASES - 1);

  sh_state_t          st;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sreg;
  logic               done_q;

  wire accept      = (st == SH_IDLE) && start;
  wire high_phase  = (st == SH_SHIFT) && cnt[0];
  wire last_nibble = high_phase && (cnt == LAST_PH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SH_IDLE;
      cnt    <= '0;
      sreg   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        SH_IDLE: begin
          if (accept) begin
            sreg <= frame;
            cnt  <= '0;
            st   <= SH_LEAD;
          end
        end
        SH_LEAD: st <= SH_SHIFT;
        SH_SHIFT: begin
          cnt <= cnt + 1'b1;
          if (high_phase) sreg <= {sreg[FRAME_W-NIB_W-1:0], {NIB_W{1'b0}}};
          if (last_nibble) st <= SH_TAIL;
        end
        SH_TAIL: begin
          st     <= SH_IDLE;
          done_q <= 1'b1;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign ready = (st == SH_IDLE);
  assign cs_n  = (st == SH_IDLE);
  assign sclk  = high_phase;
  assign qd    = sreg[FRAME_W-1 -: NIB_W];
  assign done  = done_q;

  a_r7_clk_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  a_r7_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(qd));
  a_r8_select_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !sclk);
  a_r8_tail_after_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !$past(sclk));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));
  a_r10_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(start));

endmodule

// File: rtl/dds_profile_serializer.sv
module dds_profile_serializer
  import dps_pkg::*;
#(
  parameter int  FRAME_BYTES = 16,
  parameter int  NIB_W       = 4,
  localparam int FRAME_W     = FRAME_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       chan,
  input  logic [1:0]       mode,
  input  logic [31:0]      ftw,
  input  logic [15:0]      phase,
  input  logic [10:0]      amp,
  output logic             ready,
  output logic             sclk,
  output logic             cs_n,
  output logic [NIB_W-1:0] qd,
  output logic             done
);

  logic [FRAME_W-1:0] frame_w;

  dps_frame_packer #(.FRAME_BYTES(FRAME_BYTES)) u_pack (
    .chan  (chan),
    .mode  (mode),
    .ftw   (ftw),
    .phase (phase),
    .amp   (amp),
    .frame (frame_w)
  );

  dps_nibble_shifter #(.FRAME_W(FRAME_W), .NIB_W(NIB_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .frame (frame_w),
    .ready (ready),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .qd    (qd),
    .done  (done)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cs_n && !sclk && ready && !done));

endmodule

// File: tb/dds_profile_serializer_test.sv
module dds_profile_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  chan = '0;
  logic [1:0]  mode = '0;
  logic [31:0] ftw = '0;
  logic [15:0] phase = '0;
  logic [10:0] amp = '0;
  logic        ready, sclk, cs_n, done;
  logic [3:0]  qd;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dds_profile_serializer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .mode(mode),
    .ftw(ftw), .phase(phase), .amp(amp), .ready(ready), .sclk(sclk),
    .cs_n(cs_n), .qd(qd), .done(done)
  );

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Expected byte k of the frame, written from the requirement text.
  function automatic logic [7:0] want_byte(input int k, input logic [1:0] c, input logic [1:0] m,
                                           input logic [31:0] f, input logic [15:0] p, input logic [10:0] a);
    int s, aw, pw;
    s  = m * 2 + (16 << c);
    aw = (a % 1024) + ((a < 1024) ? 4096 : 0);
    pw = p % 16384;
    case (k)
      0, 2:    return 8'h00;
      1, 3:    return 8'(s);
      4:       return 8'h06;
      5:       return 8'(aw / 65536);
      6:       return 8'(aw / 256);
      7:       return 8'(aw);
      8:       return 8'h05;
      9:       return 8'(pw / 256);
      10:      return 8'(pw);
      11:      return 8'h04;
      default: return 8'(f >> (8 * (15 - k)));
    endcase
  endfunction

  function automatic string group_req(input int k);
    if (k < 4) return "R3";
    if (k < 8) return "R4";
    if (k < 12) return "R5";
    return "R6";
  endfunction

  task automatic send(input logic [1:0] c, input logic [1:0] m, input logic [31:0] f,
                      input logic [15:0] p, input logic [10:0] a, input bit poke_busy);
    logic [3:0] nib [32];
    int nn, low_cycles, done_cnt, done_at, first_low_sclk, last_low_sclk, prev_sclk;
    int bad_stable, bad_clk, busy_ready_bad, restart_bad;
    logic [3:0] prev_qd;
    nn = 0; low_cycles = 0; done_cnt = 0; done_at = -1;
    first_low_sclk = -1; last_low_sclk = -1; prev_sclk = 0;
    bad_stable = 0; bad_clk = 0; busy_ready_bad = 0; restart_bad = 0;
    prev_qd = qd;
    @(negedge clk);
    chan = c; mode = m; ftw = f; phase = p; amp = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 72; cyc++) begin
      if (poke_busy && cyc == 20) begin
        start = 1'b1; chan = ~c; mode = ~m; ftw = ~f; phase = ~p; amp = 11'd5;
      end
      if (poke_busy && cyc == 21) start = 1'b0;
      if (sclk && cs_n) bad_clk++;
      if (sclk && qd !== prev_qd) bad_stable++;
      if (!cs_n) begin
        if (low_cycles == 0) first_low_sclk = sclk;
        low_cycles++;
        last_low_sclk = sclk;
        if (ready) busy_ready_bad++;
      end
      if (sclk && nn < 32) begin
        nib[nn] = qd;
        nn++;
      end
      if (done) begin
        done_cnt++;
        if (done_at < 0) done_at = cyc;
      end
      if (cyc > 66 && !cs_n) restart_bad++;
      prev_qd = qd;
      prev_sclk = sclk;
      @(negedge clk);
    end
    check("R2", "nibble count", nn, 32);
    check("R2", "select low cycles", low_cycles, 66);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] got;
      got = (nn == 32) ? {nib[2*k], nib[2*k+1]} : 8'hxx;
      check(group_req(k), $sformatf("byte %0d", k), got, want_byte(k, c, m, f, p, a));
    end
    check("R7", "clock or data misbehaviour", bad_clk + bad_stable, 0);
    check("R8", "first select cycle sclk", first_low_sclk, 0);
    check("R8", "last select cycle sclk", last_low_sclk, 0);
    check("R9", "done pulses", done_cnt, 1);
    check("R9", "done cycle", done_at, 66);
    check("R10", "ready while busy", busy_ready_bad, 0);
    if (poke_busy) check("R10", "burst after busy start", restart_bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd9137));
    repeat (3) @(negedge clk);
    check("R1", "cs_n in reset", cs_n, 1);
    check("R1", "sclk in reset", sclk, 0);
    check("R1", "ready in reset", ready, 1);
    check("R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {cs_n, sclk, ready, done}, 4'b1010);

    // Directed corners of the amplitude and phase fields and each channel.
    send(2'd0, 2'd3, 32'h1234_5678, 16'h2abc, 11'd1024, 0);
    send(2'd1, 2'd2, 32'hdead_beef, 16'hffff, 11'd1023, 0);
    send(2'd2, 2'd1, 32'h0000_0001, 16'h0000, 11'd0,    0);
    send(2'd3, 2'd0, 32'h8000_0000, 16'hc001, 11'd512,  1);
    for (int i = 0; i < 12; i++) begin
      send(2'($urandom), 2'($urandom), $urandom, 16'($urandom), 11'($urandom % 1025), (i == 5));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule